// File: doc/BRIEF.md
# Paged Command and Interrupt Register File

This block is the host-facing register file of a network controller. The host sees sixteen byte-wide offsets. Offset 0 always holds the command byte. The meaning of offsets 1 to 15 depends on a two-bit page field kept in the top of that command byte. Some offsets return one register when read and load a different register when written. The command byte also holds the run/stop state, a self-clearing transmit request and a three-bit remote-transfer command.

The stop command does not act at once. The controller first waits for any frame movement that the datapath reports as busy. It then halts and raises a read-only reset-status flag in the interrupt status byte. Datapath event pulses set seven latched status bits. The host clears them by writing ones. A mask byte gates the status bits into a single interrupt line.

The transmit and receive datapaths and the buffer memory sit outside this block. They drive the event, busy, completion and local-address inputs. They consume the active, transmit-request, remote-command, abort and ring-boundary outputs.

Top module: `nic_pagereg`

## Requirements
- R1: After reset the command byte reads 0x21 and the interrupt status byte reads 0x80, with `active`, `tx_req` and `irq` low and `rdma_cmd` = 3'b100. Command byte layout: bit 0 = stopping or stopped, bit 1 = running, bit 2 = transmit request, bits 5:3 = remote command, bits 7:6 = page.
- R2: Every write to offset 0 loads the page field from bits 7:6, and offset 0 reaches the command byte on every page. Page code 11 is reserved, and page 1 carries no register of this block. On both of these pages, offsets 1 to 15 read 0x00 and writes to them have no effect.
- R3: On page 0, offsets 1 and 2 read the low and high byte of `local_addr`, and writes to them load `ring_start` and `ring_stop`. On page 2, offsets 1 and 2 read `ring_start` and `ring_stop` back, and writes to them have no effect.
- R4: A command write with bit 1 set and bit 0 clear makes `active` high at the next edge and clears the reset-status bit.
- R5: A command write with bit 0 set, made while running, keeps `active` high as long as `dp_busy` is high. At the first edge where `dp_busy` is low, `active` drops and status bit 7 sets in the same cycle.
- R6: Writing 1 to command bit 2 raises `tx_req`, and writing 0 there leaves it unchanged. A `tx_done` pulse clears it. A write of 1 in the same cycle as `tx_done` leaves it set.
- R7: Command bits 5:3 load `rdma_cmd` for the codes 001 (remote read), 010 (remote write) and 011 (send packet). Any code 1xx (abort) is also stored and produces a one-cycle `rdma_abort` pulse after the write. The code 000 is not allowed and leaves `rdma_cmd` unchanged.
- R8: Interrupt status lives at page 0, offset 7. Bits 0 to 6 (received, transmitted, receive error, transmit error, ring overwrite, counter overflow, remote transfer done) latch the matching `evt_set` pulse. Writing 1 to a bit clears it, and a set pulse in the same cycle wins over the clear.
- R9: Status bit 7 (reset status) ignores host writes. It also sets on a ring-overwrite event (`evt_set[4]`). A `pkt_removed` pulse clears it while `active` is high, and has no effect on it while halted.
- R10: The mask is written at page 0, offset 15 and read at page 2, offset 15. Mask bit 7 always reads 0. `irq` is high exactly when some status bit among 0 to 6 and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Host byte offset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from address and page |
| evt_set | input | 7 | Datapath event pulses, one per status bit 0..6 |
| dp_busy | input | 1 | Frame movement in progress |
| tx_done | input | 1 | Transmission finished or aborted |
| pkt_removed | input | 1 | A packet was taken out of the receive ring |
| local_addr | input | 16 | Current local memory transfer address |
| active | output | 1 | Controller running (not halted) |
| tx_req | output | 1 | Transmit request pending |
| rdma_cmd | output | 3 | Remote transfer command |
| rdma_abort | output | 1 | One-cycle pulse after an abort command |
| ring_start | output | 8 | Receive ring first page |
| ring_stop | output | 8 | Receive ring end page |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: seven event bits and a 16-bit local address. With those values every status bit and every mask bit can be reached, and the high-address read returns a full byte. The bench visits all four page codes. It holds `dp_busy` across several cycles to observe the drain window, and it drives the set-versus-clear and write-versus-completion collisions in the same cycle.

// File: rtl/nic_pagereg_pkg.sv
package nic_pagereg_pkg;

  localparam int BYTE_W = 8;

  // page field codes (command bits 7:6)
  typedef enum logic [1:0] {
    PG_0   = 2'b00,
    PG_1   = 2'b01,
    PG_2   = 2'b10,
    PG_RSV = 2'b11
  } page_e;

  // run/stop sequencing
  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_DRAIN = 2'b01,
    ST_HALT  = 2'b10
  } run_e;

  // command byte fields
  localparam int CB_STOP   = 0;
  localparam int CB_START  = 1;
  localparam int CB_TXRQ   = 2;
  localparam int CB_RC_LO  = 3;
  localparam int CB_RC_HI  = 5;
  localparam int CB_PG_LO  = 6;
  localparam int CB_PG_HI  = 7;

  localparam logic [2:0] RCMD_IDLE = 3'b100;

  // status byte fields
  localparam int EV_OVW  = 4;
  localparam int RST_BIT = 7;

  // offsets
  localparam logic [3:0] OFS_CMD = 4'd0;
  localparam logic [3:0] OFS_LO  = 4'd1;
  localparam logic [3:0] OFS_HI  = 4'd2;
  localparam logic [3:0] OFS_ISR = 4'd7;
  localparam logic [3:0] OFS_IMR = 4'd15;

endpackage

// File: rtl/nic_pagereg_cmd.sv
module nic_pagereg_cmd
  import nic_pagereg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_wr,
  input  logic [BYTE_W-1:0] cr_wdata,
  input  logic              dp_busy,
  input  logic              tx_done,
  output page_e             page,
  output logic              active,
  output logic              tx_req,
  output logic [2:0]        rdma_cmd,
  output logic              rdma_abort,
  output logic              start_pulse,
  output logic              halt_entry,
  output logic [BYTE_W-1:0] cr_rdata
);

  run_e        state_q, state_nx;
  page_e       page_q;
  logic        tx_q, tx_nx, tx_en;
  logic [2:0]  rc_q;
  logic [2:0]  rc_wr;
  logic        rc_en;
  logic        abort_q, abort_nx;
  logic        stop_cmd;

  assign stop_cmd    = cr_wr && cr_wdata[CB_STOP];
  assign start_pulse = cr_wr && !cr_wdata[CB_STOP] && cr_wdata[CB_START];
  assign rc_wr       = cr_wdata[CB_RC_HI:CB_RC_LO];
  assign rc_en       = cr_wr && (rc_wr != 3'b000);

  always_comb begin
    state_nx = state_q;
    if (stop_cmd) begin
      if (state_q == ST_RUN) state_nx = ST_DRAIN;
    end else if (start_pulse) begin
      state_nx = ST_RUN;
    end
    if (state_q == ST_DRAIN && state_nx == ST_DRAIN && !dp_busy)
      state_nx = ST_HALT;
  end

  assign halt_entry = (state_q == ST_DRAIN) && (state_nx == ST_HALT);

  always_comb begin
    tx_nx = tx_q;
    if (tx_done) tx_nx = 1'b0;
    if (cr_wr && cr_wdata[CB_TXRQ]) tx_nx = 1'b1;
  end
  assign tx_en    = tx_done || cr_wr;
  assign abort_nx = cr_wr && cr_wdata[CB_RC_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HALT;
      page_q  <= PG_0;
      tx_q    <= 1'b0;
      rc_q    <= RCMD_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      abort_q <= abort_nx;
      if (cr_wr) page_q <= page_e'(cr_wdata[CB_PG_HI:CB_PG_LO]);
      if (tx_en) tx_q <= tx_nx;
      if (rc_en) rc_q <= rc_wr;
    end
  end

  assign page       = page_q;
  assign active     = (state_q != ST_HALT);
  assign tx_req     = tx_q;
  assign rdma_cmd   = rc_q;
  assign rdma_abort = abort_q;
  assign cr_rdata   = {page_q, rc_q, tx_q, (state_q == ST_RUN), (state_q != ST_RUN)};

  // R5: drain holds while traffic is in flight
  a_r5_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && dp_busy && !start_pulse) |=> (active && state_q == ST_DRAIN));

  // R4: a start command runs the controller next cycle
  a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (active && cr_rdata[CB_START]));

  // R6: completion clears the request unless re-requested
  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !(cr_wr && cr_wdata[CB_TXRQ])) |=> !tx_req);

  // R7: code 000 keeps the remote command
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr && cr_wdata[CB_RC_HI:CB_RC_LO] == 3'b000) |=> $stable(rdma_cmd));

  // R7: abort pulse lasts one cycle and accompanies an abort code
  a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdma_abort |-> (rdma_cmd[2] && $past(cr_wr)));

endmodule

// File: rtl/nic_pagereg_isr.sv
module nic_pagereg_isr
  import nic_pagereg_pkg::*;
#(
  parameter int NUM_EV = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] evt_set,
  input  logic              clr_wr,
  input  logic              imr_wr,
  input  logic [NUM_EV-1:0] wdata,
  input  logic              rst_set,
  input  logic              rst_clr,
  output logic [BYTE_W-1:0] isr_rdata,
  output logic [BYTE_W-1:0] imr_rdata,
  output logic              irq
);

  localparam int PAD_W = BYTE_W - 1 - NUM_EV;

  logic [NUM_EV-1:0] stat_q, stat_nx, clr_vec, mask_q;
  logic              stat_en;
  logic              rst_q, rst_nx, rst_en;

  assign clr_vec = clr_wr ? wdata : '0;

  for (genvar b = 0; b < NUM_EV; b++) begin : g_bit
    // set has priority over the host clear
    assign stat_nx[b] = evt_set[b] | (stat_q[b] & ~clr_vec[b]);
  end

  assign stat_en = clr_wr || (|evt_set);
  assign rst_en  = rst_set || rst_clr;
  assign rst_nx  = rst_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      rst_q  <= 1'b1;
    end else begin
      if (stat_en) stat_q <= stat_nx;
      if (imr_wr)  mask_q <= wdata;
      if (rst_en)  rst_q  <= rst_nx;
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign isr_rdata = {rst_q, {PAD_W{1'b0}}, stat_q};
    assign imr_rdata = {1'b0, {PAD_W{1'b0}}, mask_q};
  end else begin : g_nopad
    assign isr_rdata = {rst_q, stat_q};
    assign imr_rdata = {1'b0, mask_q};
  end

  assign irq = |(stat_q & mask_q);

  // R8: a set pulse is visible after the edge, even under a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((isr_rdata[NUM_EV-1:0] & $past(evt_set)) == $past(evt_set)));

  // R8: write-one clears bits with no concurrent set
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (|(wdata & ~evt_set))) |=> ((isr_rdata[NUM_EV-1:0] & $past(wdata & ~evt_set)) == '0));

  // R9: reset status set requests are honoured
  a_r9_rst_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rst_set |=> isr_rdata[RST_BIT]);

  // R10: the line only rises after a mask write or a masked event
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(imr_wr) || (|($past(evt_set) & imr_rdata[NUM_EV-1:0]))));

endmodule

// File: rtl/nic_pagereg_map.sv
module nic_pagereg_map
  import nic_pagereg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  page_e              page,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [LADDR_W-1:0] local_addr,
  input  logic [BYTE_W-1:0]  cr_rdata,
  input  logic [BYTE_W-1:0]  isr_rdata,
  input  logic [BYTE_W-1:0]  imr_rdata,
  output logic               cr_wr,
  output logic               clr_wr,
  output logic               imr_wr,
  output logic [BYTE_W-1:0]  ring_start,
  output logic [BYTE_W-1:0]  ring_stop,
  output logic [BYTE_W-1:0]  rdata
);

  localparam int EXT_W = 2 * BYTE_W;

  logic [EXT_W-1:0]  ladr_ext;
  logic [BYTE_W-1:0] start_q, stop_q;
  logic              start_wr, stop_wr, pg0_wr;

  assign ladr_ext = EXT_W'(local_addr);

  // write decode
  assign cr_wr    = wr && (addr == ADDR_W'(OFS_CMD));
  assign pg0_wr   = wr && (page == PG_0);
  assign start_wr = pg0_wr && (addr == ADDR_W'(OFS_LO));
  assign stop_wr  = pg0_wr && (addr == ADDR_W'(OFS_HI));
  assign clr_wr   = pg0_wr && (addr == ADDR_W'(OFS_ISR));
  assign imr_wr   = pg0_wr && (addr == ADDR_W'(OFS_IMR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      if (start_wr) start_q <= wdata;
      if (stop_wr)  stop_q  <= wdata;
    end
  end

  // read decode
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CMD)) begin
      rdata = cr_rdata;
    end else begin
      case (page)
        PG_0: begin
          if (addr == ADDR_W'(OFS_LO))       rdata = ladr_ext[BYTE_W-1:0];
          else if (addr == ADDR_W'(OFS_HI))  rdata = ladr_ext[EXT_W-1:BYTE_W];
          else if (addr == ADDR_W'(OFS_ISR)) rdata = isr_rdata;
        end
        PG_2: begin
          if (addr == ADDR_W'(OFS_LO))       rdata = start_q;
          else if (addr == ADDR_W'(OFS_HI))  rdata = stop_q;
          else if (addr == ADDR_W'(OFS_IMR)) rdata = imr_rdata;
        end
        default: rdata = '0;
      endcase
    end
  end

  assign ring_start = start_q;
  assign ring_stop  = stop_q;

  // R2: writes on the reserved page leave the ring bounds alone
  a_r2_rsv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && page == PG_RSV && addr != ADDR_W'(OFS_CMD)) |=> ($stable(ring_start) && $stable(ring_stop)));

  // R3: page 2 bound offsets are read-only
  a_r3_p2_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && page == PG_2 && addr != ADDR_W'(OFS_CMD)) |=> ($stable(ring_start) && $stable(ring_stop)));

endmodule

// File: rtl/nic_pagereg.sv
module nic_pagereg
  import nic_pagereg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_EV  = 7,
  parameter int LADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_wr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic [NUM_EV-1:0]  evt_set,
  input  logic               dp_busy,
  input  logic               tx_done,
  input  logic               pkt_removed,
  input  logic [LADDR_W-1:0] local_addr,
  output logic               active,
  output logic               tx_req,
  output logic [2:0]         rdma_cmd,
  output logic               rdma_abort,
  output logic [7:0]         ring_start,
  output logic [7:0]         ring_stop,
  output logic               irq
);

  page_e             page;
  logic              cr_wr, clr_wr, imr_wr;
  logic              start_pulse, halt_entry;
  logic              rst_set, rst_clr;
  logic [BYTE_W-1:0] cr_rdata, isr_rdata, imr_rdata;

  nic_pagereg_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_wr       (cr_wr),
    .cr_wdata    (host_wdata),
    .dp_busy     (dp_busy),
    .tx_done     (tx_done),
    .page        (page),
    .active      (active),
    .tx_req      (tx_req),
    .rdma_cmd    (rdma_cmd),
    .rdma_abort  (rdma_abort),
    .start_pulse (start_pulse),
    .halt_entry  (halt_entry),
    .cr_rdata    (cr_rdata)
  );

  assign rst_set = halt_entry || evt_set[EV_OVW];
  assign rst_clr = start_pulse || (pkt_removed && active);

  nic_pagereg_isr #(.NUM_EV(NUM_EV)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_set   (evt_set),
    .clr_wr    (clr_wr),
    .imr_wr    (imr_wr),
    .wdata     (host_wdata[NUM_EV-1:0]),
    .rst_set   (rst_set),
    .rst_clr   (rst_clr),
    .isr_rdata (isr_rdata),
    .imr_rdata (imr_rdata),
    .irq       (irq)
  );

  nic_pagereg_map #(.ADDR_W(ADDR_W), .LADDR_W(LADDR_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .page       (page),
    .addr       (host_addr),
    .wr         (host_wr),
    .wdata      (host_wdata),
    .local_addr (local_addr),
    .cr_rdata   (cr_rdata),
    .isr_rdata  (isr_rdata),
    .imr_rdata  (imr_rdata),
    .cr_wr      (cr_wr),
    .clr_wr     (clr_wr),
    .imr_wr     (imr_wr),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .rdata      (host_rdata)
  );

  // R5: halting drops active and raises reset status together
  a_r5_halt_flags: assert property (@(posedge clk) disable iff (!rst_n)
    halt_entry |=> (!active && isr_rdata[RST_BIT]));

  // R9: a removal while halted leaves reset status standing
  a_r9_halted_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && pkt_removed && !start_pulse && isr_rdata[RST_BIT]) |=> isr_rdata[RST_BIT]);

endmodule

// File: tb/nic_pagereg_tb_top.sv
module nic_pagereg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [6:0]  evt_set = '0;
  logic        dp_busy = 1'b0;
  logic        tx_done = 1'b0;
  logic        pkt_removed = 1'b0;
  logic [15:0] local_addr = 16'hBEEF;
  logic        active, tx_req, rdma_abort, irq;
  logic [2:0]  rdma_cmd;
  logic [7:0]  ring_start, ring_stop;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nic_pagereg dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
    .dp_busy(dp_busy), .tx_done(tx_done), .pkt_removed(pkt_removed),
    .local_addr(local_addr), .active(active), .tx_req(tx_req),
    .rdma_cmd(rdma_cmd), .rdma_abort(rdma_abort), .ring_start(ring_start),
    .ring_stop(ring_stop), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic pulse_evt(input logic [6:0] m);
    @(negedge clk); evt_set = m;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R1 cmd", v, 8'h21);
    rd(7, v); chk("R1 isr", v, 8'h80);
    chk("R1 active", {7'd0, active}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx_req", {7'd0, tx_req}, 8'h00);
    chk("R1 rdma", {5'd0, rdma_cmd}, 8'h04);
  endtask

  task automatic t_start;
    logic [7:0] v;
    wr(0, 8'h02);
    chk("R4 active", {7'd0, active}, 8'h01);
    rd(0, v); chk("R4 cmd", v, 8'h22);
    rd(7, v); chk("R4 rst cleared", v, 8'h00);
  endtask

  task automatic t_pages;
    logic [7:0] v;
    wr(1, 8'h46); wr(2, 8'h80);
    chk("R3 ring_start", ring_start, 8'h46);
    chk("R3 ring_stop", ring_stop, 8'h80);
    rd(1, v); chk("R3 p0 laddr lo", v, 8'hEF);
    rd(2, v); chk("R3 p0 laddr hi", v, 8'hBE);
    wr(0, 8'h80);
    rd(0, v); chk("R2 cmd on p2", v, 8'hA2);
    rd(1, v); chk("R3 p2 start", v, 8'h46);
    rd(2, v); chk("R3 p2 stop", v, 8'h80);
    wr(1, 8'h11);
    chk("R3 p2 write ignored", ring_start, 8'h46);
    wr(0, 8'h40);
    wr(1, 8'h55);
    chk("R2 p1 write ignored", ring_start, 8'h46);
    rd(1, v); chk("R2 p1 read zero", v, 8'h00);
    wr(0, 8'hC0);
    rd(0, v); chk("R2 cmd on p3", v, 8'hE2);
    wr(2, 8'h33);
    chk("R2 p3 write ignored", ring_stop, 8'h80);
    pulse_evt(7'h01);
    rd(7, v); chk("R2 p3 read zero", v, 8'h00);
    wr(0, 8'h00);
    rd(7, v); chk("R8 event latched", v, 8'h01);
  endtask

  task automatic t_isr;
    logic [7:0] v;
    wr(7, 8'h01);
    rd(7, v); chk("R8 w1c", v, 8'h00);
    wr(15, 8'h05);
    pulse_evt(7'h02);
    chk("R10 unmasked no irq", {7'd0, irq}, 8'h00);
    pulse_evt(7'h04);
    chk("R10 masked irq", {7'd0, irq}, 8'h01);
    wr(7, 8'h04);
    chk("R10 irq after clear", {7'd0, irq}, 8'h00);
    rd(7, v); chk("R8 other bit kept", v, 8'h02);
    @(negedge clk);
    host_addr = 7; host_wdata = 8'h02; host_wr = 1'b1; evt_set = 7'h02;
    @(negedge clk);
    host_wr = 1'b0; evt_set = '0;
    rd(7, v); chk("R8 set wins clear", v, 8'h02);
    wr(7, 8'h02);
    wr(0, 8'h80);
    wr(15, 8'hFF);
    rd(15, v); chk("R10 p2 mask read", v, 8'h05);
    wr(0, 8'h00);
    wr(15, 8'hFF);
    wr(0, 8'h80);
    rd(15, v); chk("R10 mask bit7 zero", v, 8'h7F);
    wr(0, 8'h00);
    wr(15, 8'h00);
  endtask

  task automatic t_rst_bit;
    logic [7:0] v;
    wr(7, 8'h80);
    rd(7, v); chk("R9 write no set", v, 8'h00);
    pulse_evt(7'h10);
    rd(7, v); chk("R9 overwrite sets", v, 8'h90);
    wr(7, 8'h80);
    rd(7, v); chk("R9 read-only", v, 8'h90);
    @(negedge clk); pkt_removed = 1'b1;
    @(negedge clk); pkt_removed = 1'b0;
    rd(7, v); chk("R9 removal clears", v, 8'h10);
    wr(7, 8'h10);
  endtask

  task automatic t_stop;
    logic [7:0] v;
    dp_busy = 1'b1;
    wr(0, 8'h01);
    chk("R5 draining active", {7'd0, active}, 8'h01);
    rd(0, v); chk("R5 cmd draining", v, 8'h21);
    repeat (3) @(negedge clk);
    chk("R5 still active", {7'd0, active}, 8'h01);
    rd(7, v); chk("R5 no rst yet", v, 8'h00);
    dp_busy = 1'b0;
    @(negedge clk);
    chk("R5 halted", {7'd0, active}, 8'h00);
    rd(7, v); chk("R5 rst set", v, 8'h80);
    @(negedge clk); pkt_removed = 1'b1;
    @(negedge clk); pkt_removed = 1'b0;
    rd(7, v); chk("R9 halted removal ignored", v, 8'h80);
    wr(0, 8'h02);
    chk("R4 restart", {7'd0, active}, 8'h01);
    rd(7, v); chk("R4 rst cleared again", v, 8'h00);
    wr(0, 8'h01);
    chk("R5 idle drain first", {7'd0, active}, 8'h01);
    @(negedge clk);
    chk("R5 idle halted", {7'd0, active}, 8'h00);
    wr(0, 8'h02);
  endtask

  task automatic t_tx;
    wr(0, 8'h04);
    chk("R6 set", {7'd0, tx_req}, 8'h01);
    wr(0, 8'h00);
    chk("R6 zero no effect", {7'd0, tx_req}, 8'h01);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk("R6 done clears", {7'd0, tx_req}, 8'h00);
    @(negedge clk);
    host_addr = 0; host_wdata = 8'h04; host_wr = 1'b1; tx_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; tx_done = 1'b0;
    chk("R6 write wins done", {7'd0, tx_req}, 8'h01);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_rdma;
    logic [7:0] v;
    wr(0, 8'h08);
    chk("R7 read code", {5'd0, rdma_cmd}, 8'h01);
    chk("R7 no abort", {7'd0, rdma_abort}, 8'h00);
    wr(0, 8'h10);
    chk("R7 write code", {5'd0, rdma_cmd}, 8'h02);
    wr(0, 8'h18);
    chk("R7 send code", {5'd0, rdma_cmd}, 8'h03);
    wr(0, 8'h00);
    chk("R7 zero keeps", {5'd0, rdma_cmd}, 8'h03);
    wr(0, 8'h28);
    chk("R7 abort code", {5'd0, rdma_cmd}, 8'h05);
    chk("R7 abort pulse", {7'd0, rdma_abort}, 8'h01);
    @(negedge clk);
    chk("R7 abort one cycle", {7'd0, rdma_abort}, 8'h00);
    rd(0, v); chk("R7 cmd readback", v, 8'h2A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_pages();
    t_isr();
    t_rst_bit();
    t_stop();
    t_tx();
    t_rdma();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule